// File: doc/BRIEF.md
# Four-Channel Timestamp Capture Unit

This block holds a bank of independent capture channels. Each channel copies the current value of one of two free-running time bases into its own capture register when its trigger fires. A channel is triggered by one of two sources, chosen per channel. The first source is a chosen transition on the channel's input pin. The second is a software write strobe aimed at the low byte of that channel's capture register. The strobe carries no data into the register: only the time base value is stored.

Pin inputs are asynchronous. Each pin is brought into the unit clock domain by a two-stage synchronizer. A small per-channel state machine then tracks the synchronized level and reports transitions. The machine has three states. PRIME is entered on reset. Once the synchronizer has filled, PRIME moves to LOW or to HIGH, following the synchronized level, and this move raises no event. The move LOW→HIGH is a rising transition and HIGH→LOW is a falling transition. A transition raises an event only if the channel's edge selection enables that direction.

Every capture sets a sticky per-channel flag. Software clears the flag by writing 1 to it. A capture in the same cycle as a clear keeps the flag set.

Top module: `capu_top`

## Requirements
- R1: After reset every capture register reads 0 and every flag reads 0.
- R2: With `trig_sel`=0 and edge code 2'b01 (rising), a 0→1 change on the pin, driven after clock edge k, loads the register and sets the flag at edge k+3 and not earlier.
- R3: With edge code 2'b10 (falling), only 1→0 pin changes capture.
- R4: With edge code 2'b11 (both), each direction of pin change captures.
- R5: With edge code 2'b00, pin changes never capture.
- R6: With `trig_sel`=1, a one-cycle `sw_lo_wr` pulse captures the selected time base value seen at that same edge, and sets the flag.
- R7: A channel with `trig_sel`=1 ignores its pin, and a channel with `trig_sel`=0 ignores its `sw_lo_wr` strobe.
- R8: `base_sel`=0 captures `tbase_a` and `base_sel`=1 captures `tbase_b`, chosen per channel.
- R9: A set flag stays set until a 1 is written to its bit in `flag_clr`.
- R10: When a capture trigger and a clear of the same channel fall in one cycle, the flag is set afterwards and the register holds the new value.
- R11: A pin level already present when reset is released is not treated as a transition.
- R12: A trigger on one channel leaves the other channels' registers and flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Unit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbase_a | input | 16 | First time base |
| tbase_b | input | 16 | Second time base |
| cap_pin | input | 4 | Asynchronous capture pins, one per channel |
| trig_sel | input | 4 | Per channel: 0 selects the pin trigger, 1 selects the software trigger |
| edge_sel | input | 8 | Two bits per channel: bit 0 enables rising, bit 1 enables falling |
| base_sel | input | 4 | Per channel time base select |
| sw_lo_wr | input | 4 | Low-byte write strobe, one per channel |
| flag_clr | input | 4 | Write-1-to-clear strobe for the flags |
| cap_val | output | 64 | Capture registers, channel n at bits 16n+15:16n |
| cap_flag | output | 4 | Sticky capture flags |

## Verification
The capture trigger and the write-1 flag clear can land on the same channel in the same cycle. The bench provokes this by first setting a channel's flag with a software strobe. It then pulses `sw_lo_wr` and `flag_clr` for that channel together, with a fresh time base value. The bench expects the flag to remain 1 and the register to hold the new value. A clear applied alone must drop the flag, which shows that the clear path itself works.

// File: rtl/capu_pkg.sv
package capu_pkg;
    typedef enum logic [1:0] {
        PS_PRIME = 2'd0,
        PS_LOW   = 2'd1,
        PS_HIGH  = 2'd2
    } pin_state_e;
endpackage

// File: rtl/capu_sync.sv
module capu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic vld
);
    logic [STAGES-1:0] sh;
    logic [STAGES-1:0] fill;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            fill <= '0;
        end else begin
            sh   <= {sh[STAGES-2:0], d};
            fill <= {fill[STAGES-2:0], 1'b1};
        end
    end

    assign q   = sh[STAGES-1];
    assign vld = fill[STAGES-1];
endmodule

// File: rtl/capu_edge_fsm.sv
module capu_edge_fsm
    import capu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvl,
    input  logic       vld,
    input  logic [1:0] edge_en,
    output logic       evt
);
    pin_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_PRIME;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        evt = 1'b0;
        unique case (state)
            PS_PRIME: if (vld) nxt = lvl ? PS_HIGH : PS_LOW;
            PS_LOW: if (lvl) begin
                nxt = PS_HIGH;
                evt = edge_en[0];
            end
            PS_HIGH: if (!lvl) begin
                nxt = PS_LOW;
                evt = edge_en[1];
            end
            default: nxt = PS_PRIME;
        endcase
    end

    a_r5_none_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_en == 2'b00) |-> !evt);
endmodule

// File: rtl/capu_channel.sv
module capu_channel #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] tbase_a,
    input  logic [TW-1:0] tbase_b,
    input  logic          pin,
    input  logic          trig_sel,
    input  logic [1:0]    edge_en,
    input  logic          base_sel,
    input  logic          sw_stb,
    input  logic          clr,
    output logic [TW-1:0] cap_q,
    output logic          flag_q
);
    logic pin_s, pin_vld, pin_evt, trig;
    logic [TW-1:0] base;

    capu_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin), .q(pin_s), .vld(pin_vld)
    );

    capu_edge_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .lvl(pin_s), .vld(pin_vld),
        .edge_en(edge_en), .evt(pin_evt)
    );

    assign base = base_sel ? tbase_b : tbase_a;
    assign trig = trig_sel ? sw_stb : pin_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (trig) cap_q <= base;
            if (trig)     flag_q <= 1'b1;
            else if (clr) flag_q <= 1'b0;
        end
    end

    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> flag_q);
    a_r10_capture_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel && sw_stb && clr) |=> flag_q);
    a_r6_sw_value: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel && sw_stb) |=> (cap_q == $past(base_sel ? tbase_b : tbase_a)));
    a_r7_value_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(cap_q) || flag_q));
endmodule

// File: rtl/capu_top.sv
module capu_top #(
    parameter int NCH = 4,
    parameter int TW  = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TW-1:0]   tbase_a,
    input  logic [TW-1:0]   tbase_b,
    input  logic [NCH-1:0]  cap_pin,
    input  logic [NCH-1:0]  trig_sel,
    input  logic [2*NCH-1:0] edge_sel,
    input  logic [NCH-1:0]  base_sel,
    input  logic [NCH-1:0]  sw_lo_wr,
    input  logic [NCH-1:0]  flag_clr,
    output logic [NCH*TW-1:0] cap_val,
    output logic [NCH-1:0]  cap_flag
);
    for (genvar i = 0; i < NCH; i++) begin : g_ch
        capu_channel #(.TW(TW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .tbase_a(tbase_a), .tbase_b(tbase_b),
            .pin(cap_pin[i]), .trig_sel(trig_sel[i]),
            .edge_en(edge_sel[2*i +: 2]), .base_sel(base_sel[i]),
            .sw_stb(sw_lo_wr[i]), .clr(flag_clr[i]),
            .cap_q(cap_val[i*TW +: TW]), .flag_q(cap_flag[i])
        );
    end
endmodule

// File: tb/sim_capu_top.sv
module sim_capu_top;
    logic clk = 1'b0;
    logic rst_n;
    logic [15:0] tbase_a, tbase_b;
    logic [3:0] cap_pin, trig_sel, base_sel, sw_lo_wr, flag_clr;
    logic [7:0] edge_sel;
    logic [63:0] cap_val;
    logic [3:0] cap_flag;
    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    capu_top u0 (
        .clk(clk), .rst_n(rst_n), .tbase_a(tbase_a), .tbase_b(tbase_b),
        .cap_pin(cap_pin), .trig_sel(trig_sel), .edge_sel(edge_sel),
        .base_sel(base_sel), .sw_lo_wr(sw_lo_wr), .flag_clr(flag_clr),
        .cap_val(cap_val), .cap_flag(cap_flag)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] val(input int ch);
        return cap_val[ch*16 +: 16];
    endfunction

    task automatic clear(input logic [3:0] m);
        flag_clr = m; step(1); flag_clr = '0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0; tbase_a = 16'h1234; tbase_b = 16'hBEEF;
        cap_pin = 4'b1000; trig_sel = '0; base_sel = '0;
        sw_lo_wr = '0; flag_clr = '0; edge_sel = 8'b01_00_00_00;
        step(3); rst_n = 1'b1; step(1);
        chk("R1 values", cap_val[31:0], 32'h0);
        chk("R1 values hi", cap_val[63:32], 32'h0);
        chk("R1 flags", cap_flag, 4'h0);
        step(6);
        chk("R11 level at release", cap_flag, 4'h0);
    endtask

    task automatic t_rise;
        edge_sel[1:0] = 2'b01; base_sel[0] = 1'b0;
        cap_pin[0] = 1'b1; step(2);
        chk("R2 not early", cap_flag[0], 1'b0);
        step(1);
        chk("R2 flag", cap_flag[0], 1'b1);
        chk("R2 value", val(0), 16'h1234);
        clear(4'b0001);
    endtask

    task automatic t_fall;
        edge_sel[3:2] = 2'b10; base_sel[1] = 1'b1;
        cap_pin[1] = 1'b1; step(5);
        chk("R3 rise ignored", cap_flag[1], 1'b0);
        tbase_b = 16'h0F0F; cap_pin[1] = 1'b0; step(3);
        chk("R3 flag", cap_flag[1], 1'b1);
        chk("R8 base b", val(1), 16'h0F0F);
        clear(4'b0010);
    endtask

    task automatic t_both;
        edge_sel[5:4] = 2'b11; base_sel[2] = 1'b0;
        tbase_a = 16'h2222; cap_pin[2] = 1'b1; step(3);
        chk("R4 rise", val(2), 16'h2222);
        clear(4'b0100);
        tbase_a = 16'h3333; cap_pin[2] = 1'b0; step(3);
        chk("R4 fall", val(2), 16'h3333);
        chk("R4 flag", cap_flag[2], 1'b1);
        clear(4'b0100);
    endtask

    task automatic t_none;
        edge_sel[1:0] = 2'b00; tbase_a = 16'h9999;
        cap_pin[0] = 1'b0; step(3); cap_pin[0] = 1'b1; step(3);
        chk("R5 flag", cap_flag[0], 1'b0);
        chk("R5 value", val(0), 16'h1234);
    endtask

    task automatic t_sw;
        trig_sel[1] = 1'b1; base_sel[1] = 1'b1; tbase_b = 16'h4444;
        sw_lo_wr[1] = 1'b1; step(1); sw_lo_wr[1] = 1'b0;
        chk("R6 flag", cap_flag[1], 1'b1);
        chk("R6 value", val(1), 16'h4444);
        chk("R12 others flags", cap_flag & 4'b1101, 4'h0);
        chk("R12 others values", {val(0), val(2)}, {16'h1234, 16'h3333});
        clear(4'b0010);
        tbase_b = 16'h8888; cap_pin[1] = 1'b1; step(3); cap_pin[1] = 1'b0; step(3);
        chk("R7 pin ignored", {15'h0, cap_flag[1], val(1)}, {15'h0, 1'b0, 16'h4444});
        sw_lo_wr[0] = 1'b1; step(1); sw_lo_wr[0] = 1'b0; step(1);
        chk("R7 strobe ignored", {15'h0, cap_flag[0], val(0)}, {15'h0, 1'b0, 16'h1234});
    endtask

    task automatic t_base;
        trig_sel[2] = 1'b1; base_sel[1] = 1'b0; base_sel[2] = 1'b1;
        tbase_a = 16'h5555; tbase_b = 16'h6666;
        sw_lo_wr = 4'b0110; step(1); sw_lo_wr = '0;
        chk("R8 per channel", {val(1), val(2)}, {16'h5555, 16'h6666});
    endtask

    task automatic t_sticky;
        step(4);
        chk("R9 held", cap_flag, 4'b0110);
        clear(4'b0010);
        chk("R9 cleared one", cap_flag, 4'b0100);
        clear(4'b0100);
        chk("R9 cleared all", cap_flag, 4'b0000);
    endtask

    task automatic t_race;
        sw_lo_wr[1] = 1'b1; step(1); sw_lo_wr[1] = 1'b0;
        tbase_a = 16'h7777;
        sw_lo_wr[1] = 1'b1; flag_clr[1] = 1'b1; step(1);
        sw_lo_wr[1] = 1'b0; flag_clr[1] = 1'b0;
        chk("R10 flag kept", cap_flag[1], 1'b1);
        chk("R10 value", val(1), 16'h7777);
        step(2);
        chk("R10 still set", cap_flag[1], 1'b1);
    endtask

    initial begin
        #500000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_rise();
        t_fall();
        t_both();
        t_none();
        t_sw();
        t_base();
        t_sticky();
        t_race();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule